// File: doc/BRIEF.md
# Self-Triggered Strip Hit Packetizer

This block watches the discriminator levels of two orthogonal strip planes and turns each pulse on an enabled strip into one fixed-format hit record. No global trigger is involved. The rising edge of a strip level captures a free-running timestamp, and the time the level stays high is counted as time over threshold. When the level falls, the strip's finished record waits in a small per-strip holding slot.

A round-robin arbiter moves at most one finished record per cycle into an output FIFO. The FIFO feeds a valid/ready record stream. Each record carries the module identifier present when it is enqueued. If a record arrives while the FIFO is full, it is dropped. A record that finishes on a strip whose slot still holds an unserved record is also lost, because the new record replaces the old one. Both kinds of loss increment a sticky counter. Software can silence a noisy strip with the per-strip enable mask.

Strip inputs 0 to 63 belong to the X plane and inputs 64 to 127 to the Y plane. The timestamp counter advances by one count per clock.

Top module: `strip_hit_packetizer`

## Requirements
- R1: The record timestamp equals the 50-bit free-running count at the clock edge where the strip level is first sampled high. The count is 0 at the first edge after reset and rises by one per clock.
- R2: The width field holds the number of clock edges at which the strip level was sampled high, from 1 to 1023.
- R3: A pulse of more than 1023 high samples reports width 1023 and sets the overrange flag, which is bit 0 of the packet-information field. A pulse of exactly 1023 samples reports width 1023 with the flag clear.
- R4: The 8-bit channel field holds the strip index. X-plane strips map to 0..63 and Y-plane strips map to 64..127.
- R5: The record layout is fixed. Bits [49:0] hold the timestamp, [59:50] the width, [67:60] the channel, [83:68] the module identifier and [93:84] the packet information (bit 84 is the overrange flag, bits 93:85 are zero). Bits [99:94] are zero padding.
- R6: A strip whose enable bit is low produces no record. If a strip is disabled while its pulse is in progress, that pulse is discarded and produces no record, even when the strip is enabled again before the fall.
- R7: When several strips hold finished records, one is served per cycle. Service starts with the first strip above the most recently served strip and wraps around from the highest index to index 0.
- R8: A record that finds the FIFO full is dropped and the lost counter increments. The lost counter also increments when an unserved record is overwritten. It saturates and clears only on reset.
- R9: While out_valid is high and out_ready is low, out_valid and out_rec hold steady. Records leave in the order they were enqueued.
- R10: After reset, out_valid is low and the lost counter is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| strip_lvl | input | 128 | Discriminated strip levels: [63:0] X plane, [127:64] Y plane |
| strip_en | input | 128 | Per-strip enable mask |
| module_id | input | 16 | Static detector-module identifier placed in every record |
| out_ready | input | 1 | Consumer accepts the record this cycle |
| out_valid | output | 1 | A record is presented |
| out_rec | output | 100 | Hit record |
| lost_cnt | output | 16 | Sticky, saturating count of lost records |

## Verification
A bad width counter or timestamp latch shows in the first record that leaves the stream, within a few cycles of the fall. It appears as a timestamp or width field that differs from the bench's own count of edges. If the arbiter's pointer is corrupt, the records from a simultaneous fall come out in the wrong order, and the third one shows this. A FIFO occupancy error shows in two ways during a stalled burst. The lost counter does not read exactly two after ten queued records. The record at the head changes while the stream is stalled.

// File: rtl/strip_pkt_pkg.sv
package strip_pkt_pkg;
  localparam int TS_W   = 50;
  localparam int WID_W  = 10;
  localparam int CH_W   = 8;
  localparam int MOD_W  = 16;
  localparam int INFO_W = 10;
  localparam int REC_W  = 100;
  localparam int PAY_W  = TS_W + WID_W + CH_W + MOD_W + INFO_W;
  localparam int PAD_W  = REC_W - PAY_W;

  typedef struct packed {
    logic [PAD_W-1:0]  pad;
    logic [INFO_W-1:0] info;
    logic [MOD_W-1:0]  mod_id;
    logic [CH_W-1:0]   chan;
    logic [WID_W-1:0]  width;
    logic [TS_W-1:0]   ts;
  } hit_rec_t;

  // saturating width step
  function automatic logic [WID_W-1:0] wid_step(input logic [WID_W-1:0] w);
    return (w == '1) ? w : w + 1'b1;
  endfunction

  function automatic hit_rec_t pack_rec(input logic [TS_W-1:0] ts,
                                        input logic [WID_W-1:0] w,
                                        input logic sat,
                                        input logic [CH_W-1:0] ch,
                                        input logic [MOD_W-1:0] mid);
    hit_rec_t r;
    r.pad    = '0;
    r.info   = {{(INFO_W-1){1'b0}}, sat};
    r.mod_id = mid;
    r.chan   = ch;
    r.width  = w;
    r.ts     = ts;
    return r;
  endfunction
endpackage

// File: rtl/strip_tot_chan.sv
module strip_tot_chan
  import strip_pkt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             lvl,
  input  logic             en,
  input  logic [TS_W-1:0]  ts_now,
  input  logic             take,
  output logic             pend,
  output logic [TS_W-1:0]  pend_ts,
  output logic [WID_W-1:0] pend_w,
  output logic             pend_sat,
  output logic             overwrite
);
  logic             prev, active, wsat;
  logic [TS_W-1:0]  ts_lat;
  logic [WID_W-1:0] wcnt;
  logic             rise, fall, done;

  assign rise      = lvl & ~prev;
  assign fall      = ~lvl & prev;
  assign done      = en & active & fall;
  assign overwrite = done & pend & ~take;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev   <= 1'b0;
      active <= 1'b0;
      wsat   <= 1'b0;
      wcnt   <= '0;
      ts_lat <= '0;
    end else begin
      prev <= lvl;
      if (!en) begin
        active <= 1'b0;
      end else if (rise) begin
        active <= 1'b1;
        ts_lat <= ts_now;
        wcnt   <= WID_W'(1);
        wsat   <= 1'b0;
      end else if (active && lvl) begin
        if (wcnt == '1) wsat <= 1'b1;
        wcnt <= wid_step(wcnt);
      end else if (done) begin
        active <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend     <= 1'b0;
      pend_ts  <= '0;
      pend_w   <= '0;
      pend_sat <= 1'b0;
    end else if (done) begin
      pend     <= 1'b1;
      pend_ts  <= ts_lat;
      pend_w   <= wcnt;
      pend_sat <= wsat;
    end else if (take) begin
      pend <= 1'b0;
    end
  end
endmodule

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int N = 128,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     req,
  output logic [N-1:0]     gnt,
  output logic [IDX_W-1:0] gidx,
  output logic             any
);
  logic [IDX_W-1:0] last;

  always_comb begin
    int idx;
    gnt  = '0;
    gidx = '0;
    any  = 1'b0;
    for (int k = 1; k <= N; k++) begin
      idx = int'(last) + k;
      if (idx >= N) idx = idx - N;
      if (!any && req[idx[IDX_W-1:0]]) begin
        any  = 1'b1;
        gidx = idx[IDX_W-1:0];
        gnt[idx[IDX_W-1:0]] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)      last <= IDX_W'(N - 1);
    else if (any) last <= gidx;
  end
endmodule

// File: rtl/rec_fifo.sv
module rec_fifo #(
  parameter int W     = 100,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  din,
  output logic          full,
  output logic          push_ok,
  input  logic          ready,
  output logic          valid,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          pop;

  assign full    = (count == CW'(DEPTH));
  assign push_ok = push & ~full;
  assign valid   = (count != '0);
  assign pop     = valid & ready;
  assign dout    = mem[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop)     rd_ptr <= bump(rd_ptr);
      case ({push_ok, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/strip_hit_packetizer.sv
module strip_hit_packetizer
  import strip_pkt_pkg::*;
#(
  parameter int STRIPS_PER_PLANE = 64,
  parameter int FIFO_DEPTH       = 8,
  parameter int LOST_W           = 16,
  localparam int NCH             = 2 * STRIPS_PER_PLANE,
  localparam int IDX_W           = $clog2(NCH),
  localparam int FCNT_W          = $clog2(FIFO_DEPTH + 1),
  localparam int INC_W           = $clog2(NCH + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH-1:0]    strip_lvl,
  input  logic [NCH-1:0]    strip_en,
  input  logic [MOD_W-1:0]  module_id,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [REC_W-1:0]  out_rec,
  output logic [LOST_W-1:0] lost_cnt
);
  logic [TS_W-1:0]  ts_cnt;
  logic [NCH-1:0]   pend, gnt, ovw, ch_sat;
  logic [TS_W-1:0]  ch_ts [NCH];
  logic [WID_W-1:0] ch_w  [NCH];
  logic [IDX_W-1:0] gidx;
  logic             any_gnt, fifo_full, push_ok, drop_evt;
  logic [FCNT_W-1:0] fifo_count;
  hit_rec_t         sel_rec;
  logic [INC_W-1:0] lost_inc;

  always_ff @(posedge clk) begin
    if (rst) ts_cnt <= '0;
    else     ts_cnt <= ts_cnt + 1'b1;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    strip_tot_chan u_ch (
      .clk      (clk),
      .rst      (rst),
      .lvl      (strip_lvl[g]),
      .en       (strip_en[g]),
      .ts_now   (ts_cnt),
      .take     (gnt[g]),
      .pend     (pend[g]),
      .pend_ts  (ch_ts[g]),
      .pend_w   (ch_w[g]),
      .pend_sat (ch_sat[g]),
      .overwrite(ovw[g])
    );
  end

  rr_pick #(.N(NCH)) u_arb (
    .clk (clk),
    .rst (rst),
    .req (pend),
    .gnt (gnt),
    .gidx(gidx),
    .any (any_gnt)
  );

  assign sel_rec  = pack_rec(ch_ts[gidx], ch_w[gidx], ch_sat[gidx],
                             CH_W'(gidx), module_id);
  assign drop_evt = any_gnt & fifo_full;

  rec_fifo #(.W(REC_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk    (clk),
    .rst    (rst),
    .push   (any_gnt),
    .din    (sel_rec),
    .full   (fifo_full),
    .push_ok(push_ok),
    .ready  (out_ready),
    .valid  (out_valid),
    .dout   (out_rec),
    .count  (fifo_count)
  );

  always_comb begin
    lost_inc = INC_W'(drop_evt);
    for (int i = 0; i < NCH; i++) lost_inc = lost_inc + INC_W'(ovw[i]);
  end

  function automatic logic [LOST_W-1:0] sat_add(input logic [LOST_W-1:0] a,
                                                input logic [INC_W-1:0] b);
    logic [LOST_W+INC_W:0] s;
    s = (LOST_W+INC_W+1)'(a) + (LOST_W+INC_W+1)'(b);
    return (s > (LOST_W+INC_W+1)'({LOST_W{1'b1}})) ? '1 : s[LOST_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (rst) lost_cnt <= '0;
    else     lost_cnt <= sat_add(lost_cnt, lost_inc);
  end
endmodule

// File: rtl/strip_hit_packetizer_chk.sv
module strip_hit_packetizer_chk
  import strip_pkt_pkg::*;
#(
  parameter int NCH    = 128,
  parameter int LOST_W = 16,
  parameter int DEPTH  = 8,
  parameter int CW     = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [NCH-1:0]    gnt,
  input logic              any_gnt,
  input logic              drop_evt,
  input logic              out_valid,
  input logic              out_ready,
  input logic [REC_W-1:0]  out_rec,
  input logic [LOST_W-1:0] lost_cnt,
  input logic [CW-1:0]     fifo_count
);
  hit_rec_t r;
  assign r = out_rec;

  p_one_grant_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt) && (any_gnt == (gnt != '0)));

  p_lost_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> lost_cnt >= $past(lost_cnt));

  p_drop_counts_r8: assert property (@(posedge clk) disable iff (rst)
    drop_evt |=> (lost_cnt > $past(lost_cnt)) || ($past(lost_cnt) == '1));

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_rec));

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    fifo_count <= CW'(DEPTH));

  p_width_nonzero_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> r.width != '0);

  p_sat_full_r3: assert property (@(posedge clk) disable iff (rst)
    out_valid && r.info[0] |-> r.width == '1);

  p_pad_zero_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (r.pad == '0) && (r.info[INFO_W-1:1] == '0));

  p_reset_idle_r10: assert property (@(posedge clk)
    rst |=> !out_valid && (lost_cnt == '0));
endmodule

bind strip_hit_packetizer strip_hit_packetizer_chk #(
  .NCH(NCH), .LOST_W(LOST_W), .DEPTH(FIFO_DEPTH), .CW(FCNT_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .gnt       (gnt),
  .any_gnt   (any_gnt),
  .drop_evt  (drop_evt),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_rec   (out_rec),
  .lost_cnt  (lost_cnt),
  .fifo_count(fifo_count)
);

// File: tb/strip_hit_packetizer_tb.sv
module strip_hit_packetizer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 128;

  // {channel[23:16], high samples[15:0]}
  localparam logic [23:0] VEC [8] = '{
    24'h00_0001, 24'h3F_0005, 24'h40_0007, 24'h7F_0064,
    24'h21_03FF, 24'h5A_0400, 24'h07_05DC, 24'h64_0002
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NCH-1:0] strip_lvl = '0;
  logic [NCH-1:0] strip_en  = '1;
  logic [15:0] module_id = 16'hA5C3;
  logic out_ready = 1'b1;
  logic out_valid;
  logic [99:0] out_rec;
  logic [15:0] lost_cnt;

  int checks = 0;
  int errs = 0;
  longint cyc;
  logic [99:0] rec_q [64];
  int rec_n = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  strip_hit_packetizer u_dut (
    .clk(clk), .rst(rst), .strip_lvl(strip_lvl), .strip_en(strip_en),
    .module_id(module_id), .out_ready(out_ready), .out_valid(out_valid),
    .out_rec(out_rec), .lost_cnt(lost_cnt)
  );

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
    if (!rst && out_valid && out_ready) begin
      if (rec_n < 64) rec_q[rec_n] <= out_rec;
      rec_n <= rec_n + 1;
    end
  end

  task automatic chk(input string tag, input logic [99:0] act, input logic [99:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [99:0] exp_rec(input longint ts, input int ch, input int len,
                                          input logic [15:0] mid);
    logic [9:0] w;
    logic sat;
    sat = (len > 1023);
    w = sat ? 10'd1023 : 10'(len);
    return {6'b0, 9'b0, sat, mid, 8'(ch), w, 50'(ts)};
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    strip_lvl = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic pulse(input int ch, input int len, output longint ts);
    @(negedge clk);
    strip_lvl[ch] = 1'b1;
    ts = cyc;
    repeat (len) @(negedge clk);
    strip_lvl[ch] = 1'b0;
  endtask

  task automatic wait_recs(input int target);
    int t = 0;
    while (rec_n < target && t < 300) begin
      @(negedge clk);
      t++;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errs++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    longint ts;
    longint tsv [10];
    logic [99:0] held;
    int base;

    do_reset();
    // R10: idle after reset
    chk("R10 out_valid after reset", 100'(out_valid), 100'(0));
    chk("R10 lost_cnt after reset", 100'(lost_cnt), 100'(0));

    // R1 R2 R3 R4 R5: table of single pulses
    for (int i = 0; i < 8; i++) begin
      int ch, len;
      ch = int'(VEC[i][23:16]);
      len = int'(VEC[i][15:0]);
      base = rec_n;
      pulse(ch, len, ts);
      wait_recs(base + 1);
      chk($sformatf("R1 R2 R3 R4 R5 vector %0d ch %0d", i, ch),
          rec_q[base], exp_rec(ts, ch, len, module_id));
    end

    // R5: module identifier follows the input
    module_id = 16'h1234;
    base = rec_n;
    pulse(77, 3, ts);
    wait_recs(base + 1);
    chk("R5 module id field", rec_q[base], exp_rec(ts, 77, 3, 16'h1234));

    // R6: disabled strip produces nothing
    strip_en[20] = 1'b0;
    base = rec_n;
    pulse(20, 4, ts);
    repeat (20) @(negedge clk);
    chk("R6 masked strip no record", 100'(rec_n), 100'(base));
    strip_en[20] = 1'b1;

    // R6: disable in mid-pulse discards it
    @(negedge clk);
    strip_lvl[21] = 1'b1;
    repeat (3) @(negedge clk);
    strip_en[21] = 1'b0;
    @(negedge clk);
    strip_en[21] = 1'b1;
    repeat (2) @(negedge clk);
    strip_lvl[21] = 1'b0;
    repeat (20) @(negedge clk);
    chk("R6 mid-pulse disable discards", 100'(rec_n), 100'(base));
    pulse(21, 4, ts);
    wait_recs(base + 1);
    chk("R6 re-enabled strip records", rec_q[base], exp_rec(ts, 21, 4, module_id));

    // R7: round-robin after strip 10 served
    do_reset();
    base = rec_n;
    pulse(10, 2, ts);
    wait_recs(base + 1);
    chk("R7 lone strip 10", rec_q[base], exp_rec(ts, 10, 2, module_id));
    @(negedge clk);
    strip_lvl[3] = 1'b1;
    strip_lvl[12] = 1'b1;
    strip_lvl[40] = 1'b1;
    ts = cyc;
    repeat (3) @(negedge clk);
    strip_lvl[3] = 1'b0;
    strip_lvl[12] = 1'b0;
    strip_lvl[40] = 1'b0;
    wait_recs(base + 4);
    chk("R7 first served 12", rec_q[base+1], exp_rec(ts, 12, 3, module_id));
    chk("R7 second served 40", rec_q[base+2], exp_rec(ts, 40, 3, module_id));
    chk("R7 wrap served 3", rec_q[base+3], exp_rec(ts, 3, 3, module_id));

    // R8 R9: overflow while stalled
    out_ready = 1'b0;
    base = rec_n;
    for (int i = 0; i < 10; i++) begin
      pulse(50, 2, tsv[i]);
      repeat (2) @(negedge clk);
    end
    repeat (5) @(negedge clk);
    chk("R8 lost count after overflow", 100'(lost_cnt), 100'(2));
    chk("R9 valid while stalled", 100'(out_valid), 100'(1));
    held = out_rec;
    repeat (4) @(negedge clk);
    chk("R9 record stable under stall", out_rec, held);
    chk("R9 head is oldest", held, exp_rec(tsv[0], 50, 2, module_id));
    out_ready = 1'b1;
    repeat (20) @(negedge clk);
    chk("R8 drained count equals depth", 100'(rec_n - base), 100'(8));
    chk("R9 last drained in order", rec_q[base+7], exp_rec(tsv[7], 50, 2, module_id));
    chk("R8 lost count sticky", 100'(lost_cnt), 100'(2));

    do_reset();
    chk("R10 lost cleared by reset", 100'(lost_cnt), 100'(0));
    finish_run();
  end
endmodule